// File: doc/BRIEF.md
# Timestamp Queue Register Interface

This block is the host-facing half of a packet timestamp unit. The capture logic fills two independent queues with 64-bit timestamps, one for the receive path and one for the transmit path. Software reaches both queues through one 32-bit register port. It reads a queue's fill level first. It then takes entries out one at a time. To take an entry it clears the shared command register and then sets that queue's pop bit. Next it polls the same register until the bit reads back as 1. Finally it reads the latched entry as an upper word and a lower word.

Both queues share the command register. Each queue has its own pop bit and its own flush bit. A pop acts only when its bit goes from 0 to 1. A queue that is full drops any new timestamp and records the loss in a sticky flag. Register reads are combinational from the address. Writes take effect on the clock edge at which the write strobe is sampled.

Top module: `tsq_regif`

## Requirements
- R1: After reset, both fill levels are 0, the command register reads 0 and all four entry words read 0.
- R2: Register byte offsets: command 0x50, receive level 0x54, transmit level 0x58, receive entry upper/lower 0x60/0x64, transmit entry upper/lower 0x68/0x6C. Any other offset reads 0.
- R3: Each push pulse stores its 64-bit stamp in that queue. The level register's low bits give the number of stored entries.
- R4: Writing the command register with bit 0 (transmit) or bit 2 (receive) set, when the previous command write had that bit clear, removes the oldest entry of that queue. The removed entry goes to that queue's entry registers: stamp bits 63:32 in the upper word and 31:0 in the lower word. Entries leave in arrival order.
- R5: A command write that keeps a pop bit at 1 while it was already 1 removes nothing. The level and the entry words stay unchanged.
- R6: After a pop command, the command register reads that pop bit as 1 until the next command write that clears it. Bits other than 0 and 2 always read 0.
- R7: Each queue holds DEPTH entries (16 by default). A push to a full queue is dropped and sets bit 31 of that level register. Bit 31 stays set across pops.
- R8: A pop command on an empty queue still sets its readback bit. It leaves the entry words unchanged.
- R9: A push and a pop on the same queue in the same cycle leave the level unchanged and keep arrival order. On a full queue the push is then accepted.
- R10: A command write with bit 1 empties the transmit queue and bit 3 empties the receive queue (0xA empties both). Emptying clears the level, the overflow flag and the entry words.
- R11: Activity on one queue never changes the other queue's level, flag or entry words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Receive timestamp valid strobe |
| rx_stamp | input | 64 | Receive timestamp |
| tx_push | input | 1 | Transmit timestamp valid strobe |
| tx_stamp | input | 64 | Transmit timestamp |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The bench builds the block with its default DEPTH of 16. At that depth a short burst of 18 pushes reaches the full boundary, the dropped pushes and the sticky flag. A push and a pop in the same cycle on a full queue is then also in reach. The same depth keeps drain-and-compare runs short enough to cover both queues and both flush bits, including a flush of one queue while the other still holds entries.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int STAMP_W = 64;
  localparam int LANES   = 2;   // lane 0 = transmit, lane 1 = receive

  localparam logic [7:0] OFF_CMD   = 8'h50;
  localparam logic [7:0] OFF_RXLVL = 8'h54;
  localparam logic [7:0] OFF_TXLVL = 8'h58;
  localparam logic [7:0] OFF_RXHI  = 8'h60;
  localparam logic [7:0] OFF_RXLO  = 8'h64;
  localparam logic [7:0] OFF_TXHI  = 8'h68;
  localparam logic [7:0] OFF_TXLO  = 8'h6C;

  // command bit that pops a lane (also its readback position)
  function automatic int pop_pos(input int lane);
    return (lane == 0) ? 0 : 2;
  endfunction

  // command bit that empties a lane
  function automatic int flush_pos(input int lane);
    return (lane == 0) ? 1 : 3;
  endfunction

  // level register word: sticky loss flag on top, entry count below
  function automatic logic [31:0] level_word(input logic [31:0] cnt, input logic lost);
    return {lost, cnt[30:0]};
  endfunction

  // next ring index with wrap at depth
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  import tsq_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= PW'(ring_next(32'(wr_ptr), DEPTH));
      if (rd_en) rd_ptr <= PW'(ring_next(32'(rd_ptr), DEPTH));
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tsq_lane.sv
module tsq_lane #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  stamp,
  input  logic          pop_cmd,
  input  logic          flush_cmd,
  input  logic          ack_clr,
  output logic [W-1:0]  held,
  output logic [CW-1:0] level,
  output logic          lost,
  output logic          ack,
  output logic          popped,
  output logic          accepted,
  output logic          full,
  output logic          empty
);
  logic [W-1:0] head;

  // a pop frees a slot in the same cycle, so a full queue takes the push
  assign popped   = pop_cmd && !empty && !flush_cmd;
  assign accepted = push && (!full || popped) && !flush_cmd;

  tsq_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (flush_cmd),
    .wr_en   (accepted),
    .wr_data (stamp),
    .rd_en   (popped),
    .head    (head),
    .count   (level),
    .full    (full),
    .empty   (empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      lost <= 1'b0;
      ack  <= 1'b0;
    end else begin
      if (flush_cmd) begin
        held <= '0;
        lost <= 1'b0;
      end else begin
        if (popped) held <= head;
        if (push && !accepted) lost <= 1'b1;
      end
      if (pop_cmd)      ack <= 1'b1;
      else if (ack_clr) ack <= 1'b0;
    end
  end
endmodule

// File: rtl/tsq_regif.sv
module tsq_regif #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_push,
  input  logic [63:0] rx_stamp,
  input  logic        tx_push,
  input  logic [63:0] tx_stamp,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  import tsq_pkg::*;

  logic                cmd_wr;
  logic [LANES-1:0]    armed_q;
  logic [LANES-1:0]    pop_cmd, flush_cmd, ack_clr;
  logic [LANES-1:0]    push_v, lost_v, ack_v, popped_v, acc_v, full_v, empty_v;
  logic [STAMP_W-1:0]  stamp_v [LANES];
  logic [STAMP_W-1:0]  held_v  [LANES];
  logic [CW-1:0]       level_v [LANES];

  // named events for the checker
  logic          tx_pop, rx_pop, tx_flush, rx_flush, tx_ack, rx_ack;
  logic          tx_popd, rx_popd, tx_ovf, rx_ovf, tx_empty, rx_empty;
  logic [CW-1:0] tx_lvl, rx_lvl;
  logic [63:0]   tx_held, rx_held;

  assign cmd_wr     = reg_wr && (reg_addr == OFF_CMD);
  assign push_v     = {rx_push, tx_push};
  assign stamp_v[0] = tx_stamp;
  assign stamp_v[1] = rx_stamp;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int PB = pop_pos(g);
    localparam int FB = flush_pos(g);

    assign pop_cmd[g]   = cmd_wr && reg_wdata[PB] && !armed_q[g];
    assign flush_cmd[g] = cmd_wr && reg_wdata[FB];
    assign ack_clr[g]   = cmd_wr && !reg_wdata[PB];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed_q[g] <= 1'b0;
      else if (cmd_wr) armed_q[g] <= reg_wdata[PB];
    end

    tsq_lane #(.DEPTH(DEPTH), .W(STAMP_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_v[g]),
      .stamp     (stamp_v[g]),
      .pop_cmd   (pop_cmd[g]),
      .flush_cmd (flush_cmd[g]),
      .ack_clr   (ack_clr[g]),
      .held      (held_v[g]),
      .level     (level_v[g]),
      .lost      (lost_v[g]),
      .ack       (ack_v[g]),
      .popped    (popped_v[g]),
      .accepted  (acc_v[g]),
      .full      (full_v[g]),
      .empty     (empty_v[g])
    );
  end

  assign tx_pop   = pop_cmd[0];
  assign rx_pop   = pop_cmd[1];
  assign tx_flush = flush_cmd[0];
  assign rx_flush = flush_cmd[1];
  assign tx_ack   = ack_v[0];
  assign rx_ack   = ack_v[1];
  assign tx_popd  = popped_v[0];
  assign rx_popd  = popped_v[1];
  assign tx_ovf   = lost_v[0];
  assign rx_ovf   = lost_v[1];
  assign tx_empty = empty_v[0];
  assign rx_empty = empty_v[1];
  assign tx_lvl   = level_v[0];
  assign rx_lvl   = level_v[1];
  assign tx_held  = held_v[0];
  assign rx_held  = held_v[1];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CMD: begin
        reg_rdata[pop_pos(0)] = tx_ack;
        reg_rdata[pop_pos(1)] = rx_ack;
      end
      OFF_RXLVL: reg_rdata = level_word(32'(rx_lvl), rx_ovf);
      OFF_TXLVL: reg_rdata = level_word(32'(tx_lvl), tx_ovf);
      OFF_RXHI:  reg_rdata = rx_held[63:32];
      OFF_RXLO:  reg_rdata = rx_held[31:0];
      OFF_TXHI:  reg_rdata = tx_held[63:32];
      OFF_TXLO:  reg_rdata = tx_held[31:0];
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsq_regif_chk.sv
module tsq_regif_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_push,
  input logic          rx_push,
  input logic          tx_pop,
  input logic          rx_pop,
  input logic          tx_popd,
  input logic          rx_popd,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic          tx_ack,
  input logic          rx_ack,
  input logic          tx_ovf,
  input logic          tx_empty,
  input logic [CW-1:0] tx_lvl,
  input logic [CW-1:0] rx_lvl,
  input logic [63:0]   tx_held
);
  // R7
  tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= CW'(DEPTH));
  // R7
  rx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl <= CW'(DEPTH));
  // R6
  tx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> tx_ack);
  // R6
  rx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> rx_ack);
  // R7
  tx_sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf && !tx_flush |=> tx_ovf);
  // R9
  tx_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && tx_popd && !tx_flush |=> $stable(tx_lvl));
  // R9
  rx_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_popd && !rx_flush |=> $stable(rx_lvl));
  // R8
  tx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop && tx_empty && !tx_flush |=> $stable(tx_held));
  // R10
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_lvl == '0) && !tx_ovf);
  // R10
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_lvl == '0));
endmodule

bind tsq_regif tsq_regif_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_push  (tx_push),
  .rx_push  (rx_push),
  .tx_pop   (tx_pop),
  .rx_pop   (rx_pop),
  .tx_popd  (tx_popd),
  .rx_popd  (rx_popd),
  .tx_flush (tx_flush),
  .rx_flush (rx_flush),
  .tx_ack   (tx_ack),
  .rx_ack   (rx_ack),
  .tx_ovf   (tx_ovf),
  .tx_empty (tx_empty),
  .tx_lvl   (tx_lvl),
  .rx_lvl   (rx_lvl),
  .tx_held  (tx_held)
);

// File: tb/tb_tsq_regif.sv
`timescale 1ns/100ps
module tb_tsq_regif;
  localparam int DEPTH = 16;
  localparam logic [7:0] A_CMD = 8'h50, A_RXL = 8'h54, A_TXL = 8'h58;
  localparam logic [7:0] A_RXH = 8'h60, A_RXO = 8'h64, A_TXH = 8'h68, A_TXO = 8'h6C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_push = 1'b0, tx_push = 1'b0, reg_wr = 1'b0;
  logic [63:0] rx_stamp = '0, tx_stamp = '0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;

  // scoreboard: lane 0 = transmit, lane 1 = receive
  logic [63:0] model_tx[$];
  logic [63:0] model_rx[$];
  logic [63:0] last_out [2];
  logic        model_lost [2];

  always #2.5 clk = ~clk;

  tsq_regif #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .rx_push(rx_push), .rx_stamp(rx_stamp),
    .tx_push(tx_push), .tx_stamp(tx_stamp),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int msize(input int lane);
    return (lane == 0) ? model_tx.size() : model_rx.size();
  endfunction

  // driver: push a stamp and record the expected outcome
  task automatic push(input int lane, input logic [63:0] v);
    @(negedge clk);
    if (lane == 0) begin tx_push = 1'b1; tx_stamp = v; end
    else           begin rx_push = 1'b1; rx_stamp = v; end
    if (msize(lane) >= DEPTH) model_lost[lane] = 1'b1;
    else if (lane == 0) model_tx.push_back(v);
    else model_rx.push_back(v);
    @(negedge clk);
    tx_push = 1'b0; rx_push = 1'b0;
  endtask

  task automatic check_level(input int lane, input string tag);
    logic [31:0] v;
    rd(lane == 0 ? A_TXL : A_RXL, v);
    chk(tag, v, {model_lost[lane], 31'(msize(lane))});
  endtask

  task automatic check_words(input int lane, input string tag);
    logic [31:0] h, l;
    rd(lane == 0 ? A_TXH : A_RXH, h);
    rd(lane == 0 ? A_TXO : A_RXO, l);
    chk({tag, " upper"}, h, last_out[lane][63:32]);
    chk({tag, " lower"}, l, last_out[lane][31:0]);
  endtask

  function automatic void model_pop(input int lane);
    if (lane == 0 && model_tx.size() > 0) last_out[0] = model_tx.pop_front();
    if (lane == 1 && model_rx.size() > 0) last_out[1] = model_rx.pop_front();
  endfunction

  // monitor: issue a pop, confirm readback, compare against the scoreboard
  task automatic pop(input int lane, input string tag);
    logic [31:0] v;
    logic [31:0] bitv;
    bitv = (lane == 0) ? 32'h1 : 32'h4;
    wr(A_CMD, 32'h0);
    wr(A_CMD, bitv);
    model_pop(lane);
    rd(A_CMD, v);
    chk("R6 readback", v, bitv);
    check_words(lane, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    last_out[0] = '0; last_out[1] = '0;
    model_lost[0] = 1'b0; model_lost[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CMD, v); chk("R1 command", v, 0);
    check_level(0, "R1 tx level");
    check_level(1, "R1 rx level");
    check_words(0, "R1 tx words");
    check_words(1, "R1 rx words");
    // R2 unmapped offsets
    rd(8'h5C, v); chk("R2 unmapped 5C", v, 0);
    rd(8'h00, v); chk("R2 unmapped 00", v, 0);

    // R3 / R11 fill levels
    for (int i = 0; i < 3; i++) push(0, {32'hA100_0000 + i, 32'h0000_B000 + 3 * i});
    for (int i = 0; i < 2; i++) push(1, {32'hC200_0000 + i, 32'hD000_0000 + 7 * i});
    check_level(0, "R3 tx level");
    check_level(1, "R11 rx level");

    // R4 ordered drain of transmit; R11 receive untouched
    for (int i = 0; i < 3; i++) begin
      pop(0, "R4 tx entry");
      check_level(0, "R4 tx level");
    end
    check_level(1, "R11 rx level after tx pops");

    // R5 repeated 1 on armed bit pops nothing
    push(0, 64'h1111_2222_3333_4444);
    wr(A_CMD, 32'h1);
    check_level(0, "R5 level held");
    check_words(0, "R5 words held");

    // R4 receive drain
    pop(1, "R4 rx entry");
    pop(1, "R4 rx entry");
    check_level(1, "R4 rx level");
    check_words(0, "R11 tx words after rx pops");

    // R8 pop on empty receive queue
    pop(1, "R8 rx empty pop");
    check_level(1, "R8 rx level");

    // R6 readback cleared by a zero write; other bits read 0
    wr(A_CMD, 32'hFFFF_FFF0);
    rd(A_CMD, v); chk("R6 cleared", v, 0);

    // R7 overflow: fill transmit queue past depth
    for (int i = 0; i < DEPTH + 1; i++) push(0, {32'hE000_0000 + i, 32'h0F00_0000 + i});
    check_level(0, "R7 full with flag");
    pop(0, "R7 entry after overflow");
    check_level(0, "R7 flag sticky");

    // R9 push and pop same cycle on a full queue
    push(0, 64'h5555_0000_6666_0001);
    check_level(0, "R9 refilled");
    wr(A_CMD, 32'h0);
    @(negedge clk);
    tx_push = 1'b1; tx_stamp = 64'h7777_8888_9999_AAAA;
    reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = 32'h1;
    model_pop(0);
    model_tx.push_back(64'h7777_8888_9999_AAAA);
    @(negedge clk);
    tx_push = 1'b0; reg_wr = 1'b0;
    check_level(0, "R9 level unchanged");
    check_words(0, "R9 popped head");

    // R10 flush transmit only
    push(1, 64'h0BAD_F00D_1234_5678);
    wr(A_CMD, 32'h2);
    model_tx.delete(); model_lost[0] = 1'b0; last_out[0] = '0;
    check_level(0, "R10 tx flushed");
    check_words(0, "R10 tx words cleared");
    check_level(1, "R11 rx kept across tx flush");
    pop(1, "R11 rx entry after tx flush");

    // R9 ordering after flush: same-cycle push/pop on a partly filled queue
    push(0, 64'h1); push(0, 64'h2);
    wr(A_CMD, 32'h0);
    @(negedge clk);
    tx_push = 1'b1; tx_stamp = 64'h3;
    reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = 32'h1;
    model_pop(0); model_tx.push_back(64'h3);
    @(negedge clk);
    tx_push = 1'b0; reg_wr = 1'b0;
    pop(0, "R9 order second");
    pop(0, "R9 order third");

    // R10 flush both
    push(1, 64'hFEED_0000_0000_0001);
    wr(A_CMD, 32'hA);
    model_tx.delete(); model_rx.delete();
    model_lost[0] = 1'b0; model_lost[1] = 1'b0;
    last_out[0] = '0; last_out[1] = '0;
    check_level(0, "R10 both tx");
    check_level(1, "R10 both rx");
    check_words(1, "R10 rx words cleared");

    finish_run();
  end
endmodule